// File: doc/BRIEF.md
# Twin-Predicated Vector Element Sequencer

This block steps through the elements of one vectorised register operation and hands the datapath a pair of element indices for every step: one index into the source vector and one into the destination vector. Each side carries its own predicate mask and its own zeroing flag. A side whose zeroing is off walks past every element whose mask bit is clear before a step goes out. A side whose zeroing is on visits every element. This lets a packed source feed a scattered destination, or a scattered source feed a packed destination, with no extra logic outside the block.

A one-cycle `start` pulse captures the vector length, both masks and both zeroing flags, and the loop begins. Each step is offered with a valid/ready handshake. The indices hold until the datapath accepts the step. With each accepted step the datapath may raise `stop_req` to end the loop early. The loop also ends when either index runs out of elements. In both cases `done` pulses for one cycle. A vector length of zero runs one element, as for a scalar operation. A length above the build-time maximum is cut down to that maximum. When destination zeroing is on and the destination mask bit is clear, `dst_clear` tells the datapath to write zero in place of the result.

Top module: `twin_pred_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `step_valid`, `done`, `busy` and `dst_clear` are all low.
- R2: A `vec_len` of zero is treated as a length of one. With all mask bits set, exactly one step with source index 0 and destination index 0 is issued.
- R3: A `vec_len` above the parameter `MAXVL` is treated as `MAXVL`. No issued index reaches the effective length.
- R4: For a side whose zeroing flag is low, every issued index of that side has its mask bit (bit n of the mask for index n) set. Each index is the lowest such position at or after the side's current position.
- R5: For a side whose zeroing flag is high, elements whose mask bit is clear are not skipped, so that side's index visits every position in order.
- R6: `dst_clear` is high during a step exactly when destination zeroing is on and the destination mask bit at `dst_idx` is clear.
- R7: After an accepted step without a stop request, both the source and the destination positions advance by one before any further skipping.
- R8: The loop ends without issuing a step as soon as either position is at or past the effective length, whether before or after skipping. `done` is then high for exactly one cycle and `busy` falls with it.
- R9: When `stop_req` is high in the cycle a step is accepted, no further step is issued, `done` pulses in the next cycle and `busy` falls.
- R10: While `step_valid` is high and `step_ready` is low, `step_valid`, `src_idx`, `dst_idx` and `dst_clear` hold their values.
- R11: A `start` pulse while `busy` is high is ignored. The running loop goes on with the parameters captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that captures the settings and begins a loop |
| vec_len | input | VLW | Requested vector length (0 means one element) |
| src_mask | input | MAXVL | Source predicate, bit n for element n |
| dst_mask | input | MAXVL | Destination predicate, bit n for element n |
| src_zeroing | input | 1 | Source zeroing flag (no skipping on the source side) |
| dst_zeroing | input | 1 | Destination zeroing flag (no skipping; clear bits give zero writes) |
| step_ready | input | 1 | Datapath accepts the offered step |
| stop_req | input | 1 | Datapath asks to end the loop after the step being accepted |
| busy | output | 1 | A loop is in progress |
| step_valid | output | 1 | A step is offered |
| src_idx | output | VLW | Source element index of the offered step |
| dst_idx | output | VLW | Destination element index of the offered step |
| dst_clear | output | 1 | Write zero to the destination element for this step |
| done | output | 1 | One-cycle pulse when the loop ends |

## Verification
On every cycle the assertions check several properties. An unaccepted step holds still. Indices stay below the captured length. A non-zeroing side only ever offers a position whose mask bit is set. `done` lasts one cycle. A stop or a normal acceptance leads to the right next state. Only the bench's scenarios can show that the exact sequence of index pairs and zero flags is right. These scenarios cover a packed source feeding a scattered destination, zeroing on either side, lengths of zero and above the maximum, masks that run out before the length, an early stop and a restart attempt during a loop. The bench also shows that `done` fires once per loop with no step lost or added.

// File: rtl/twin_seq_pkg.sv
package twin_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SKIP  = 2'd1,
    ST_ISSUE = 2'd2
  } seq_state_t;

  localparam int SIDE_SRC = 0;
  localparam int SIDE_DST = 1;
  localparam int NSIDES   = 2;

endpackage

// File: rtl/tps_cursor.sv
module tps_cursor #(
  parameter int MAXVL = 16,
  parameter int VLW   = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [MAXVL-1:0] mask_in,
  input  logic             zero_in,
  input  logic             skip,
  input  logic             adv,
  input  logic [VLW-1:0]   limit,
  input  logic             offering,
  output logic [VLW-1:0]   pos,
  output logic             need_skip,
  output logic             at_end,
  output logic             bit_clr
);

  logic [MAXVL-1:0] mask_r;
  logic             zero_r;
  logic [MAXVL-1:0] shifted;
  logic             bit_here;

  always_comb begin
    shifted   = mask_r >> pos;
    bit_here  = shifted[0];
    need_skip = !zero_r && !bit_here;
    bit_clr   = zero_r && !bit_here;
    at_end    = (pos >= limit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_r <= '0;
      zero_r <= 1'b0;
      pos    <= '0;
    end else if (load) begin
      mask_r <= mask_in;
      zero_r <= zero_in;
      pos    <= '0;
    end else if (skip || adv) begin
      pos <= pos + 1'b1;
    end
  end

  // R4: a non-zeroing side never offers a masked-off element
  p_mask_honoured_r4: assert property (@(posedge clk) disable iff (rst)
    (offering && !zero_r) |-> bit_here);

  // R8: the position never runs beyond the captured length
  p_pos_bounded_r8: assert property (@(posedge clk) disable iff (rst)
    pos <= limit);

endmodule

// File: rtl/tps_ctrl.sv
module tps_ctrl
  import twin_seq_pkg::*;
#(
  parameter int MAXVL = 16,
  parameter int VLW   = $clog2(MAXVL + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [VLW-1:0] vec_len,
  input  logic           s_need,
  input  logic           d_need,
  input  logic           s_end,
  input  logic           d_end,
  input  logic           d_bitclr,
  input  logic           step_ready,
  input  logic           stop_req,
  output logic           load,
  output logic           s_skip,
  output logic           d_skip,
  output logic           adv,
  output logic [VLW-1:0] limit,
  output logic           busy,
  output logic           step_valid,
  output logic           dst_clear,
  output logic           done
);

  localparam logic [VLW-1:0] MAXV = VLW'(MAXVL);
  localparam logic [VLW-1:0] ONE  = VLW'(1);

  seq_state_t     state;
  logic           in_skip;
  logic           end_now;
  logic           go_issue;
  logic           accept;
  logic [VLW-1:0] len_eff;

  always_comb begin
    if (vec_len == '0)       len_eff = ONE;
    else if (vec_len > MAXV) len_eff = MAXV;
    else                     len_eff = vec_len;
  end

  always_comb begin
    in_skip  = (state == ST_SKIP);
    load     = (state == ST_IDLE) && start;
    end_now  = in_skip && (s_end || d_end);
    s_skip   = in_skip && !end_now && s_need;
    d_skip   = in_skip && !end_now && d_need;
    go_issue = in_skip && !end_now && !s_need && !d_need;
    accept   = step_valid && step_ready;
    adv      = accept && !stop_req;
    busy     = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      limit      <= '0;
      step_valid <= 1'b0;
      dst_clear  <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            limit <= len_eff;
            state <= ST_SKIP;
          end
        end
        ST_SKIP: begin
          if (end_now) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (go_issue) begin
            step_valid <= 1'b1;
            dst_clear  <= d_bitclr;
            state      <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (accept) begin
            step_valid <= 1'b0;
            dst_clear  <= 1'b0;
            if (stop_req) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: done lasts a single cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: a stop on acceptance ends the loop at once
  p_stop_ends_r9: assert property (@(posedge clk) disable iff (rst)
    (step_valid && step_ready && stop_req) |=> (done && !busy && !step_valid));

  // R7: a normal acceptance returns to skipping with no step on offer
  p_accept_moves_r7: assert property (@(posedge clk) disable iff (rst)
    (step_valid && step_ready && !stop_req) |=> (busy && !step_valid && !done));

  // R11: start while busy leaves the captured length alone
  p_restart_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(limit));

endmodule

// File: rtl/twin_pred_seq.sv
module twin_pred_seq
  import twin_seq_pkg::*;
#(
  parameter int MAXVL = 16,
  parameter int VLW   = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [VLW-1:0]   vec_len,
  input  logic [MAXVL-1:0] src_mask,
  input  logic [MAXVL-1:0] dst_mask,
  input  logic             src_zeroing,
  input  logic             dst_zeroing,
  input  logic             step_ready,
  input  logic             stop_req,
  output logic             busy,
  output logic             step_valid,
  output logic [VLW-1:0]   src_idx,
  output logic [VLW-1:0]   dst_idx,
  output logic             dst_clear,
  output logic             done
);

  logic             load, adv, s_skip, d_skip;
  logic [VLW-1:0]   limit;
  logic [MAXVL-1:0] side_mask [NSIDES];
  logic             side_zero [NSIDES];
  logic             side_skip [NSIDES];
  logic [VLW-1:0]   side_pos  [NSIDES];
  logic             side_need [NSIDES];
  logic             side_end  [NSIDES];
  logic             side_clr  [NSIDES];

  always_comb begin
    side_mask[SIDE_SRC] = src_mask;
    side_mask[SIDE_DST] = dst_mask;
    side_zero[SIDE_SRC] = src_zeroing;
    side_zero[SIDE_DST] = dst_zeroing;
    side_skip[SIDE_SRC] = s_skip;
    side_skip[SIDE_DST] = d_skip;
  end

  for (genvar g = 0; g < NSIDES; g++) begin : g_side
    tps_cursor #(.MAXVL(MAXVL), .VLW(VLW)) u_cur (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .mask_in   (side_mask[g]),
      .zero_in   (side_zero[g]),
      .skip      (side_skip[g]),
      .adv       (adv),
      .limit     (limit),
      .offering  (step_valid),
      .pos       (side_pos[g]),
      .need_skip (side_need[g]),
      .at_end    (side_end[g]),
      .bit_clr   (side_clr[g])
    );
  end

  tps_ctrl #(.MAXVL(MAXVL), .VLW(VLW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .vec_len    (vec_len),
    .s_need     (side_need[SIDE_SRC]),
    .d_need     (side_need[SIDE_DST]),
    .s_end      (side_end[SIDE_SRC]),
    .d_end      (side_end[SIDE_DST]),
    .d_bitclr   (side_clr[SIDE_DST]),
    .step_ready (step_ready),
    .stop_req   (stop_req),
    .load       (load),
    .s_skip     (s_skip),
    .d_skip     (d_skip),
    .adv        (adv),
    .limit      (limit),
    .busy       (busy),
    .step_valid (step_valid),
    .dst_clear  (dst_clear),
    .done       (done)
  );

  assign src_idx = side_pos[SIDE_SRC];
  assign dst_idx = side_pos[SIDE_DST];

  // R10: an unaccepted step holds still
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (step_valid && !step_ready) |=>
      (step_valid && $stable(src_idx) && $stable(dst_idx) && $stable(dst_clear)));

  // R3: offered indices stay below the effective length
  p_idx_range_r3: assert property (@(posedge clk) disable iff (rst)
    step_valid |-> (src_idx < limit && dst_idx < limit && limit <= VLW'(MAXVL)));

  // R1: nothing is offered or reported while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !step_valid);

endmodule

// File: tb/sim_twin_pred_seq.sv
module sim_twin_pred_seq;
  localparam int MAXVL = 16;
  localparam int VLW   = $clog2(MAXVL + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [VLW-1:0]   vec_len = '0;
  logic [MAXVL-1:0] src_mask = '0, dst_mask = '0;
  logic             src_zeroing = 1'b0, dst_zeroing = 1'b0;
  logic             step_ready = 1'b0, stop_req = 1'b0;
  logic             busy, step_valid, dst_clear, done;
  logic [VLW-1:0]   src_idx, dst_idx;

  always #10 clk = ~clk;

  twin_pred_seq #(.MAXVL(MAXVL), .VLW(VLW)) u0 (
    .clk(clk), .rst(rst), .start(start), .vec_len(vec_len),
    .src_mask(src_mask), .dst_mask(dst_mask),
    .src_zeroing(src_zeroing), .dst_zeroing(dst_zeroing),
    .step_ready(step_ready), .stop_req(stop_req),
    .busy(busy), .step_valid(step_valid), .src_idx(src_idx),
    .dst_idx(dst_idx), .dst_clear(dst_clear), .done(done)
  );

  int checks = 0, errors = 0;
  logic [2*VLW:0] exp_q[$];
  string cur_req = "R1";
  int stop_at = -1, seen = 0, hold = 0, done_cnt = 0;
  bit prev_v = 0, this_stop = 0, mon_on = 0;
  logic [VLW-1:0] h_s, h_d;
  logic h_c;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // monitor: compares offered steps and drives the handshake
  always @(negedge clk) begin
    if (mon_on) begin
      if (done) done_cnt++;
      if (step_valid) begin
        if (!prev_v) begin
          if (exp_q.size() == 0) begin
            chk(0, cur_req, "unexpected step src", src_idx, -1);
          end else begin
            logic [2*VLW:0] e;
            e = exp_q.pop_front();
            chk(src_idx == e[2*VLW:VLW+1], cur_req, "src_idx", src_idx, e[2*VLW:VLW+1]);
            chk(dst_idx == e[VLW:1], cur_req, "dst_idx", dst_idx, e[VLW:1]);
            chk(dst_clear == e[0], {cur_req, " R6"}, "dst_clear", dst_clear, e[0]);
          end
          this_stop = (seen == stop_at);
          seen++;
          hold = (seen % 3 == 2) ? 2 : 0;
        end else begin
          chk(src_idx == h_s && dst_idx == h_d && dst_clear == h_c, "R10",
              "held step changed src", src_idx, h_s);
        end
        h_s = src_idx; h_d = dst_idx; h_c = dst_clear;
        if (hold == 0) begin
          step_ready = 1'b1; stop_req = this_stop;
        end else begin
          hold--; step_ready = 1'b0; stop_req = 1'b0;
        end
      end else begin
        step_ready = 1'b0; stop_req = 1'b0;
      end
      prev_v = step_valid;
    end
  end

  // driver: computes the expected steps from the requirements and starts a loop
  task automatic run(string req, int vl, logic [MAXVL-1:0] sm, logic [MAXVL-1:0] dm,
                     bit sz, bit dz, int sa, bit restart);
    int eff, s, d, n, w;
    eff = (vl == 0) ? 1 : ((vl > MAXVL) ? MAXVL : vl);
    s = 0; d = 0; n = 0;
    forever begin
      if (s >= eff || d >= eff) break;
      while (!sz && !sm[s]) begin s++; if (s >= eff) break; end
      while (!dz && !dm[d]) begin d++; if (d >= eff) break; end
      if (s >= eff || d >= eff) break;
      exp_q.push_back({VLW'(s), VLW'(d), dz && !dm[d]});
      if (n == sa) break;
      s++; d++; n++;
    end
    cur_req = req; seen = 0; stop_at = sa; done_cnt = 0;
    @(negedge clk);
    vec_len = VLW'(vl); src_mask = sm; dst_mask = dm;
    src_zeroing = sz; dst_zeroing = dz; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart) begin
      repeat (2) @(negedge clk);
      vec_len = VLW'(3); src_mask = '0; dst_mask = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (done_cnt == 0 && w < 2000) begin @(negedge clk); w++; end
    if (w >= 2000) chk(0, req, "watchdog on done", 0, 1);
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R8", {req, " done pulses"}, done_cnt, 1);
    chk(exp_q.size() == 0, req, "steps missing", exp_q.size(), 0);
    chk(!busy, "R8", {req, " busy after done"}, busy, 0);
    exp_q.delete();
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog", "run expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!step_valid && !done && !busy && !dst_clear, "R1", "outputs in reset",
        {step_valid, done, busy, dst_clear}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!step_valid && !done && !busy && !dst_clear, "R1", "outputs after reset",
        {step_valid, done, busy, dst_clear}, 0);
    mon_on = 1;
    run("R7",  8,  16'hFFFF, 16'hFFFF, 0, 0, -1, 0);
    run("R2",  0,  16'hFFFF, 16'hFFFF, 0, 0, -1, 0);
    run("R2",  0,  16'hFFFE, 16'hFFFF, 0, 0, -1, 0);
    run("R3",  20, 16'hFFFF, 16'hFFFF, 0, 0, -1, 0);
    run("R4",  16, 16'h00FF, 16'hAAAA, 0, 0, -1, 0);
    run("R4",  16, 16'h8421, 16'h00F0, 0, 0, -1, 0);
    run("R5",  6,  16'hFFFF, 16'h5555, 0, 1, -1, 0);
    run("R5",  4,  16'h0003, 16'hFFFF, 1, 0, -1, 0);
    run("R6",  9,  16'h0F0F, 16'h0033, 0, 1, -1, 0);
    run("R9",  10, 16'hFFFF, 16'hFFFF, 0, 0, 2, 0);
    run("R9",  12, 16'h0FF0, 16'h00FF, 0, 0, 0, 0);
    run("R8",  5,  16'h0000, 16'hFFFF, 0, 0, -1, 0);
    run("R8",  12, 16'hFFFF, 16'h0007, 0, 0, -1, 0);
    run("R11", 12, 16'hFFFF, 16'hFFFF, 0, 0, -1, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule